// File: doc/BRIEF.md
# Bitplane Video Shifter with Palette

This block turns display memory into a pixel stream. Memory logic hands it 16-bit words in which the bitplanes of the screen are interleaved. The block groups one word per plane and shifts the group out one pixel per clock. For each pixel it builds a palette index from the same bit position of every plane word. It then looks up a 16-entry colour table and drives 4-bit red, green and blue levels.

A two-bit mode input chooses one of three layouts:
- four planes, using all 16 colours;
- two planes, using the first four colours;
- one plane, monochrome.

In monochrome the colour table is bypassed. Each data bit lights or darkens the pixel, and bit 0 of colour entry 0 selects normal or inverted video. A processor-side port loads and reads back the colour table. A blank input forces black, and a display-enable input gates which words are taken.

Incoming words collect in a staging buffer. The buffer is copied into the shifters in one step when the current group runs out. A complete next group therefore follows the previous one with no gap.

Top module: `bitplane_shifter`

## Requirements
- R1: The colour table holds 16 entries of 12 bits: red in bits 11:8, green in bits 7:4, blue in bits 3:0. A write with `pal_we_i` high stores `pal_wdata_i` at `pal_addr_i` on the clock edge. `pal_rdata_o` shows the stored entry at `pal_addr_i` without delay.
- R2: `mode_i` encoding: 2'b00 is four planes, 2'b01 is two planes, 2'b10 and 2'b11 are one plane. A group is 4, 2 or 1 words respectively, and the k-th word of a group is plane k.
- R3: A word is taken only on a clock edge where `word_we_i` and `de_i` are both high. Strobes while `de_i` is low leave the staging buffer untouched.
- R4: Pixels leave most significant bit first, one per clock. Bit p of a pixel's colour index is plane p's bit at the pixel's position, with plane 0 giving index bit 0 (plane bits 0,1,0,1 from plane 3 down to plane 0 select entry 5).
- R5: In two-plane mode the index is {2'b00, plane1 bit, plane0 bit}, so only entries 0 to 3 are ever shown.
- R6: In one-plane mode each output channel is 4'hF when the data bit XOR bit 0 of entry 0 is 1, and 4'h0 otherwise. No other palette bit has any effect.
- R7: If `blank_i` is high in a cycle, all three colour outputs are zero after the next edge.
- R8: Pixel 0 of a group is on the outputs after the second edge following the edge that takes the group's last word. A next group that is complete in time follows pixel 15 with no gap. With no data left, the block shows colour index 0.
- R9: A colour table write does not change the pixel being shifted in the write cycle. It applies to every later pixel.
- R10: After reset the outputs are zero, all colour entries read as zero, and the staging buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Plane layout select |
| de_i | input | 1 | Display enable, gates word acceptance |
| blank_i | input | 1 | Forces black output |
| word_we_i | input | 1 | Display word strobe |
| word_i | input | 16 | Display word (one plane) |
| pal_we_i | input | 1 | Colour table write enable |
| pal_addr_i | input | 4 | Colour table entry address (write and read) |
| pal_wdata_i | input | 12 | Colour table write data |
| pal_rdata_o | output | 12 | Colour table read data |
| red_o | output | 4 | Red level |
| green_o | output | 4 | Green level |
| blue_o | output | 4 | Blue level |

## Verification
The hardest situation to reach from the ports is the staging buffer being refilled in the same edge that empties it into the shifters. This is what lets two groups run back to back. The stimulus strobes the next group's first word on exactly the edge that transfers the previous group, in each of the three modes. The bench then compares 32 consecutive pixels plus idle pixels against indices it computes from the plane words. A colour table write placed in the middle of a uniform run shows the exact pixel at which the new colour appears.

// File: rtl/vs_pkg.sv
package vs_pkg;
    localparam int VS_WORD_W = 16;
    localparam int VS_PLANES = 4;
    localparam int VS_CH_W   = 4;

    typedef enum logic [1:0] {
        VS_FOUR  = 2'b00,
        VS_TWO   = 2'b01,
        VS_ONE   = 2'b10,
        VS_ONE_B = 2'b11
    } vs_mode_e;
endpackage

// File: rtl/vs_stager.sv
module vs_stager
    import vs_pkg::*;
#(
    parameter int WORD_W = VS_WORD_W,
    parameter int PLANES = VS_PLANES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode_i,
    input  logic                           wr_i,
    input  logic                           de_i,
    input  logic [WORD_W-1:0]              word_i,
    input  logic                           take_i,
    output logic                           full_o,
    output logic [PLANES-1:0][WORD_W-1:0]  stage_o
);
    localparam int IDX_W = (PLANES > 1) ? $clog2(PLANES) : 1;

    typedef struct packed {
        logic [PLANES-1:0][WORD_W-1:0] stage;
        logic [IDX_W-1:0]              cnt;
        logic                          full;
    } stg_t;

    stg_t             st_d, st_q;
    logic [IDX_W-1:0] last_d;
    logic             accept_d;

    always_comb begin
        case (vs_mode_e'(mode_i))
            VS_FOUR: last_d = IDX_W'(PLANES - 1);
            VS_TWO:  last_d = IDX_W'(PLANES / 2 - 1);
            default: last_d = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        accept_d = wr_i && de_i && (!st_q.full || take_i);
        if (take_i) begin
            st_d.full = 1'b0;
        end
        if (accept_d) begin
            st_d.stage[st_q.cnt] = word_i;
            if (st_q.cnt == last_d) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o  = st_q.full;
    assign stage_o = st_q.stage;
endmodule

// File: rtl/vs_serializer.sv
module vs_serializer
    import vs_pkg::*;
#(
    parameter int WORD_W = VS_WORD_W,
    parameter int PLANES = VS_PLANES,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           full_i,
    input  logic [PLANES-1:0][WORD_W-1:0]  stage_i,
    output logic                           take_o,
    output logic [PLANES-1:0]              bits_o,
    output logic [CNT_W-1:0]               left_o
);
    typedef struct packed {
        logic [PLANES-1:0][WORD_W-1:0] shift;
        logic [CNT_W-1:0]              left;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d   = sh_q;
        take_o = full_i && (sh_q.left <= CNT_W'(1));
        if (take_o) begin
            sh_d.shift = stage_i;
            sh_d.left  = CNT_W'(WORD_W);
        end else if (sh_q.left != '0) begin
            for (int p = 0; p < PLANES; p++) begin
                sh_d.shift[p] = {sh_q.shift[p][WORD_W-2:0], 1'b0};
            end
            sh_d.left = sh_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_tap
        assign bits_o[p] = sh_q.shift[p][WORD_W-1];
    end

    assign left_o = sh_q.left;
endmodule

// File: rtl/vs_palette.sv
module vs_palette
    import vs_pkg::*;
#(
    parameter int PLANES  = VS_PLANES,
    parameter int CH_W    = VS_CH_W,
    localparam int ENTRIES = 1 << PLANES,
    localparam int COLOR_W = 3 * CH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [PLANES-1:0]  addr_i,
    input  logic [COLOR_W-1:0] wdata_i,
    input  logic [PLANES-1:0]  pix_idx_i,
    output logic [COLOR_W-1:0] rdata_o,
    output logic [COLOR_W-1:0] pix_color_o,
    output logic               invert_o
);
    logic [ENTRIES-1:0][COLOR_W-1:0] pal_d, pal_q;

    always_comb begin
        pal_d = pal_q;
        if (we_i) begin
            pal_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pal_q <= '0;
        end else begin
            pal_q <= pal_d;
        end
    end

    assign rdata_o     = pal_q[addr_i];
    assign pix_color_o = pal_q[pix_idx_i];
    assign invert_o    = pal_q[0][0];
endmodule

// File: rtl/bitplane_shifter.sv
module bitplane_shifter
    import vs_pkg::*;
#(
    parameter int WORD_W = VS_WORD_W,
    parameter int PLANES = VS_PLANES,
    parameter int CH_W   = VS_CH_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  de_i,
    input  logic                  blank_i,
    input  logic                  word_we_i,
    input  logic [WORD_W-1:0]     word_i,
    input  logic                  pal_we_i,
    input  logic [PLANES-1:0]     pal_addr_i,
    input  logic [3*CH_W-1:0]     pal_wdata_i,
    output logic [3*CH_W-1:0]     pal_rdata_o,
    output logic [CH_W-1:0]       red_o,
    output logic [CH_W-1:0]       green_o,
    output logic [CH_W-1:0]       blue_o
);
    localparam int COLOR_W = 3 * CH_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam logic [PLANES-1:0] TWO_MASK = PLANES'((1 << (PLANES / 2)) - 1);

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    logic                          stage_full;
    logic                          take;
    logic [PLANES-1:0][WORD_W-1:0] stage_words;
    logic [PLANES-1:0]             pix_bits;
    logic [CNT_W-1:0]              run_left;
    logic [PLANES-1:0]             pix_idx;
    logic [COLOR_W-1:0]            pix_color;
    logic                          invert;
    logic                          dot;
    rgb_t                          out_d, out_q;

    vs_stager #(.WORD_W(WORD_W), .PLANES(PLANES)) u_stager (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .wr_i    (word_we_i),
        .de_i    (de_i),
        .word_i  (word_i),
        .take_i  (take),
        .full_o  (stage_full),
        .stage_o (stage_words)
    );

    vs_serializer #(.WORD_W(WORD_W), .PLANES(PLANES)) u_serializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .full_i  (stage_full),
        .stage_i (stage_words),
        .take_o  (take),
        .bits_o  (pix_bits),
        .left_o  (run_left)
    );

    vs_palette #(.PLANES(PLANES), .CH_W(CH_W)) u_palette (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (pal_we_i),
        .addr_i      (pal_addr_i),
        .wdata_i     (pal_wdata_i),
        .pix_idx_i   (pix_idx),
        .rdata_o     (pal_rdata_o),
        .pix_color_o (pix_color),
        .invert_o    (invert)
    );

    always_comb begin
        case (vs_mode_e'(mode_i))
            VS_FOUR: pix_idx = pix_bits;
            VS_TWO:  pix_idx = pix_bits & TWO_MASK;
            default: pix_idx = '0;
        endcase
        dot = pix_bits[0] ^ invert;
    end

    always_comb begin
        out_d = out_q;
        if (blank_i) begin
            out_d = '0;
        end else if (mode_i[1]) begin
            out_d = {COLOR_W{dot}};
        end else begin
            out_d = pix_color;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign red_o   = out_q.r;
    assign green_o = out_q.g;
    assign blue_o  = out_q.b;
endmodule

// File: rtl/vs_checker.sv
module vs_checker #(
    parameter int WORD_W = 16,
    parameter int PLANES = 4,
    parameter int CH_W   = 4,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              blank_i,
    input logic              pal_we_i,
    input logic [PLANES-1:0] pal_addr_i,
    input logic [3*CH_W-1:0] pal_wdata_i,
    input logic [3*CH_W-1:0] pal_rdata_o,
    input logic [CH_W-1:0]   red_o,
    input logic [CH_W-1:0]   green_o,
    input logic [CH_W-1:0]   blue_o,
    input logic [CNT_W-1:0]  run_left
);
    p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (red_o == '0 && green_o == '0 && blue_o == '0));

    p_mono_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |=> (red_o == green_o && green_o == blue_o &&
                       (red_o == '0 || red_o == {CH_W{1'b1}})));

    p_pal_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we_i |=> (pal_addr_i != $past(pal_addr_i)) ||
                     (pal_rdata_o == $past(pal_wdata_i)));

    p_pal_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pal_we_i |=> (pal_addr_i != $past(pal_addr_i)) || $stable(pal_rdata_o));

    p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_left <= CNT_W'(WORD_W));
endmodule

bind bitplane_shifter vs_checker #(.WORD_W(WORD_W), .PLANES(PLANES), .CH_W(CH_W)) u_vs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .blank_i     (blank_i),
    .pal_we_i    (pal_we_i),
    .pal_addr_i  (pal_addr_i),
    .pal_wdata_i (pal_wdata_i),
    .pal_rdata_o (pal_rdata_o),
    .red_o       (red_o),
    .green_o     (green_o),
    .blue_o      (blue_o),
    .run_left    (run_left)
);

// File: tb/tb_bitplane_shifter.sv
`timescale 1ns/1ps
module tb_bitplane_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        de_i = 1'b1;
    logic        blank_i = 1'b0;
    logic        word_we_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        pal_we_i = 1'b0;
    logic [3:0]  pal_addr_i = '0;
    logic [11:0] pal_wdata_i = '0;
    logic [11:0] pal_rdata_o;
    logic [3:0]  red_o, green_o, blue_o;

    int checks = 0;
    int errors = 0;
    logic [11:0] shp [16];
    logic [15:0] gw [8];

    always #2 clk = ~clk;

    bitplane_shifter dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .de_i(de_i), .blank_i(blank_i),
        .word_we_i(word_we_i), .word_i(word_i), .pal_we_i(pal_we_i),
        .pal_addr_i(pal_addr_i), .pal_wdata_i(pal_wdata_i), .pal_rdata_o(pal_rdata_o),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
    );

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %03h exp %03h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] want(input logic [1:0] m, input logic [3:0] bits);
        logic d;
        if (m[1]) begin
            d = bits[0] ^ shp[0][0];
            return {12{d}};
        end else if (m == 2'b01) begin
            return shp[{2'b00, bits[1:0]}];
        end
        return shp[bits];
    endfunction

    task automatic pal_write(input logic [3:0] a, input logic [11:0] v);
        @(negedge clk);
        pal_we_i = 1'b1; pal_addr_i = a; pal_wdata_i = v;
        @(negedge clk);
        pal_we_i = 1'b0;
        shp[a] = v;
    endtask

    // Streams two groups from gw and checks 32 pixels plus idle pixels (R8).
    task automatic play(input logic [1:0] m, input logic blk, input int wr_at,
                        input logic [3:0] wa, input logic [11:0] wv, input string tag);
        int n;
        int k;
        logic [3:0] bits;
        logic [11:0] exp;
        n = (m == 2'b00) ? 4 : ((m == 2'b01) ? 2 : 1);
        mode_i = m;
        blank_i = blk;
        de_i = 1'b1;
        for (int c = 1; c <= n + 36; c++) begin
            @(negedge clk);
            pal_we_i = 1'b0;
            if (c >= n + 3) begin
                k = c - (n + 3);
                bits = '0;
                if (k < 32) begin
                    for (int p = 0; p < n; p++) begin
                        bits[p] = gw[(k / 16) * n + p][15 - (k % 16)];
                    end
                end
                exp = blk ? 12'h000 : want(m, bits);
                check($sformatf("%s pixel %0d", tag, k), {red_o, green_o, blue_o}, exp);
                if (k == wr_at) begin
                    pal_we_i = 1'b1; pal_addr_i = wa; pal_wdata_i = wv;
                end
                if (wr_at >= 0 && k == wr_at + 1) begin
                    shp[wa] = wv;
                end
            end
            if (c <= 2 * n) begin
                word_we_i = 1'b1;
                word_i = gw[c - 1];
            end else begin
                word_we_i = 1'b0;
            end
        end
        blank_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog got hang exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        for (int i = 0; i < 16; i++) shp[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 outputs at reset", {red_o, green_o, blue_o}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 outputs after reset", {red_o, green_o, blue_o}, 12'h000);
        for (int a = 0; a < 16; a++) begin
            pal_addr_i = 4'(a); #0.5;
            check($sformatf("R10 entry %0d cleared", a), pal_rdata_o, 12'h000);
        end
        // R1: load and read back every entry
        for (int a = 0; a < 16; a++) pal_write(4'(a), 12'((a * 12'h111) ^ 12'h5A3));
        for (int a = 0; a < 16; a++) begin
            pal_addr_i = 4'(a); #0.5;
            check($sformatf("R1 readback entry %0d", a), pal_rdata_o, shp[a]);
        end
        // R2 R4 R8: four planes, every index, back-to-back groups
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < 16; k++) begin
                idx = (g == 0) ? k : ((k * 7 + 3) & 15);
                for (int p = 0; p < 4; p++) gw[g * 4 + p][15 - k] = 1'(idx >> p);
            end
        play(2'b00, 1'b0, -1, 4'd0, 12'h000, "R4 four-plane");
        // R9: mid-run colour write on a uniform index 9 run
        for (int g = 0; g < 2; g++) begin
            gw[g * 4 + 0] = 16'hFFFF; gw[g * 4 + 1] = 16'h0000;
            gw[g * 4 + 2] = 16'h0000; gw[g * 4 + 3] = 16'hFFFF;
        end
        play(2'b00, 1'b0, 5, 4'd9, 12'h3C9, "R9 write timing");
        // R5: two planes, stale upper planes masked
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < 16; k++) begin
                idx = (g == 0) ? (k & 3) : (((k >> 2) ^ 1) & 3);
                for (int p = 0; p < 2; p++) gw[g * 2 + p][15 - k] = 1'(idx >> p);
            end
        play(2'b01, 1'b0, -1, 4'd0, 12'h000, "R5 two-plane");
        // R6: one plane, normal then inverted, other entry-0 bits ignored
        gw[0] = 16'hA5C3; gw[1] = 16'h0FF0;
        pal_write(4'd0, 12'h7E0);
        play(2'b10, 1'b0, -1, 4'd0, 12'h000, "R6 mono normal");
        pal_write(4'd0, 12'h001);
        play(2'b11, 1'b0, -1, 4'd0, 12'h000, "R6 mono inverted");
        // R7: blank forces black
        for (int i = 0; i < 8; i++) gw[i] = 16'hFFFF;
        play(2'b00, 1'b1, -1, 4'd0, 12'h000, "R7 blank");
        // R3: strobes with display enable low are ignored
        mode_i = 2'b00;
        @(negedge clk);
        de_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            word_we_i = 1'b1; word_i = 16'hFFFF;
            @(negedge clk);
        end
        word_we_i = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            check($sformatf("R3 no pixels while disabled %0d", i), {red_o, green_o, blue_o}, shp[0]);
        end
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < 16; k++)
                for (int p = 0; p < 4; p++) gw[g * 4 + p][15 - k] = 1'(((15 - k) ^ (g * 5)) >> p);
        play(2'b00, 1'b0, -1, 4'd0, 12'h000, "R3 staging still empty");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule